// File: doc/BRIEF.md
# Reset-Time Configuration Strap Sampler

This block sits beside a narrow memory address bus whose low pins double as board configuration straps. While reset is held, the shared pins are inputs so that pull resistors on the board can present strap values. On the first clock edge after reset is released, the block latches three straps: a core-hold strap, a configuration-retry strap and a self-test strap. Exactly four clocks later it takes over the shared pins as outputs. From then on they carry word address bits, selected per cycle from either the low or the high half of the physical address.

The core-hold and configuration-retry results are sticky flags. Each one drives its own output until software writes a 1 to its clear bit. The self-test selection is held until the next reset and is reported both on a pin and in a read port. A fresh reset assertion drops the pin drive and arms the sampler again for the next release.

Top module: `cfg_strap_sampler`

## Requirements
- R1: While rst_ni is low, pin_oe_o, core_hold_o, cfg_retry_o, self_test_o and reg_rdata_o are all 0.
- R2: On the first rising clock edge with rst_ni high after a reset, the block latches the straps from pin_i. Index 3 is core-hold, index 0 is config-retry and index 1 is self-test. The results appear on core_hold_o, cfg_retry_o and self_test_o after that edge.
- R3: Changes on pin_i after the sampling edge do not alter the latched strap results.
- R4: pin_oe_o stays low after the sampling edge and rises after the fourth rising edge that follows it. It then stays high until reset.
- R5: Asserting reset at any point, including partway through the four-clock window, clears pin_oe_o. Sampling then happens again at the next release.
- R6: A write (reg_wr_i high at a rising edge) with reg_clr_i[0]=1 clears core_hold_o, and one with reg_clr_i[1]=1 clears cfg_retry_o. Each clear bit acts only on its own flag.
- R7: A write with a clear bit of 0 leaves the matching flag unchanged. A cleared flag never sets again until the next sampling edge. The self-test result is not affected by writes.
- R8: reg_rdata_o returns {self_test, cfg_retry, core_hold} in bits 2, 1 and 0.
- R9: For each index k of pin_o, the output is addr_i[3+k] when addr_hi_i is 0 and addr_i[17+k] when addr_hi_i is 1. In other words, pins 3..8 carry address bits 3..8 or 17..22 in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 6 | Shared pins 3..8 as seen from the pad (straps) |
| addr_i | input | 23 | Physical word address |
| addr_hi_i | input | 1 | Select the high address half onto the pins |
| pin_o | output | 6 | Address value driven on shared pins 3..8 |
| pin_oe_o | output | 1 | Output enable for the shared pins |
| core_hold_o | output | 1 | Keep the processor core in reset |
| cfg_retry_o | output | 1 | Answer configuration cycles with retry |
| self_test_o | output | 1 | 1: full self-test plus bus test, 0: bus test only |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_clr_i | input | 2 | Clear bits: [0] core hold, [1] config retry |
| reg_rdata_o | output | 3 | Status read: {self_test, cfg_retry, core_hold} |

## Verification
The strap results are due one edge after release, so the bench checks them at the falling edge that follows the sampling edge. The output enable is due four edges after that, and the bench checks it low at each of the three falling edges in between and high at the fourth. A flag clear is seen at the falling edge after the write edge. The address mux is combinational and is checked a short delay after its inputs change. All eight strap combinations are swept, and a reset placed partway through the enable window checks that the sampler re-arms.

// File: rtl/cfg_strap_pkg.sv
package cfg_strap_pkg;
  localparam int unsigned PIN_LO    = 3;
  localparam int unsigned PIN_N     = 6;
  localparam int unsigned HI_OFS    = 14;
  localparam int unsigned ADDR_W    = 23;
  localparam int unsigned OE_DLY    = 4;
  localparam int unsigned RETRY_IDX = 0;
  localparam int unsigned STEST_IDX = 1;
  localparam int unsigned HOLD_IDX  = 3;
  localparam int unsigned CLR_HOLD  = 0;
  localparam int unsigned CLR_RETRY = 1;

  typedef struct packed {
    logic stest;
    logic retry;
    logic hold;
  } strap_stat_t;
endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import cfg_strap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIN_N-1:0] pin_i,
  output logic             sample_o,
  output logic             stest_o
);
  logic armed_q, stest_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      stest_q <= 1'b0;
    end else if (armed_q) begin
      armed_q <= 1'b0;
      stest_q <= pin_i[STEST_IDX];
    end
  end

  assign sample_o = armed_q;
  assign stest_o  = stest_q;

  // R3
  stest_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> $stable(stest_q));
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic strap_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // sampling edge wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (load_i) flag_q <= strap_i;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R6
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !load_i) |=> !flag_o);
  // R7
  no_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !load_i) |=> !flag_o);
  // R7
  keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i && !load_i) |=> flag_o);
endmodule

// File: rtl/oe_timer.sv
module oe_timer #(
  parameter int unsigned DLY = 4,
  localparam int unsigned CW = $clog2(DLY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic oe_o
);
  logic [CW-1:0] cnt_q;
  logic          oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      if (start_i)
        cnt_q <= CW'(1);
      else if (cnt_q != '0 && cnt_q != CW'(DLY))
        cnt_q <= cnt_q + CW'(1);
      if (cnt_q == CW'(DLY))
        oe_q <= 1'b1;
    end
  end

  assign oe_o = oe_q;

  // R4
  oe_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |=> oe_q);
  // R4
  oe_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !oe_q);
endmodule

// File: rtl/pin_addr_mux.sv
module pin_addr_mux
  import cfg_strap_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hi_i,
  output logic [PIN_N-1:0]  pin_o
);
  for (genvar k = 0; k < PIN_N; k++) begin : g_pin
    assign pin_o[k] = hi_i ? addr_i[PIN_LO+HI_OFS+k] : addr_i[PIN_LO+k];
  end
endmodule

// File: rtl/cfg_strap_sampler.sv
module cfg_strap_sampler
  import cfg_strap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIN_N-1:0]  pin_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_hi_i,
  output logic [PIN_N-1:0]  pin_o,
  output logic              pin_oe_o,
  output logic              core_hold_o,
  output logic              cfg_retry_o,
  output logic              self_test_o,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_clr_i,
  output logic [2:0]        reg_rdata_o
);
  logic        sample;
  strap_stat_t stat;

  strap_capture u_cap (
    .clk_i, .rst_ni, .pin_i,
    .sample_o(sample), .stest_o(stat.stest)
  );

  sticky_flag u_hold (
    .clk_i, .rst_ni, .load_i(sample), .strap_i(pin_i[HOLD_IDX]),
    .clr_i(reg_wr_i & reg_clr_i[CLR_HOLD]), .flag_o(stat.hold)
  );

  sticky_flag u_retry (
    .clk_i, .rst_ni, .load_i(sample), .strap_i(pin_i[RETRY_IDX]),
    .clr_i(reg_wr_i & reg_clr_i[CLR_RETRY]), .flag_o(stat.retry)
  );

  oe_timer #(.DLY(OE_DLY)) u_oe (
    .clk_i, .rst_ni, .start_i(sample), .oe_o(pin_oe_o)
  );

  pin_addr_mux u_mux (.addr_i, .hi_i(addr_hi_i), .pin_o);

  assign core_hold_o = stat.hold;
  assign cfg_retry_o = stat.retry;
  assign self_test_o = stat.stest;
  assign reg_rdata_o = stat;

  // R4
  no_drive_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample |-> !pin_oe_o);
  // R1
  rst_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!pin_oe_o && reg_rdata_o == 3'b000));
endmodule

// File: tb/sim_cfg_strap_sampler.sv
`timescale 1ns/1ps
module sim_cfg_strap_sampler;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [5:0]  pin_i = '0;
  logic [22:0] addr_i = '0;
  logic        addr_hi_i = 1'b0;
  logic [5:0]  pin_o;
  logic        pin_oe_o, core_hold_o, cfg_retry_o, self_test_o;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_clr_i = '0;
  logic [2:0]  reg_rdata_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  cfg_strap_sampler u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [1:0] clr);
    @(negedge clk_i); reg_wr_i = 1'b1; reg_clr_i = clr;
    @(negedge clk_i); reg_wr_i = 1'b0; reg_clr_i = '0;
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 8; s++) begin
      logic h, r, t;
      logic [2:0] st;
      h = s[0]; r = s[1]; t = s[2];
      @(negedge clk_i); rst_ni = 1'b0;
      pin_i = {2'b10, h, ~h, t, r};
      @(negedge clk_i); @(negedge clk_i);
      // R1 reset state
      chk("R1 oe", pin_oe_o, 0);
      chk("R1 rdata", reg_rdata_o, 0);
      chk("R1 flags", {core_hold_o, cfg_retry_o, self_test_o}, 0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      // R2 latched after sampling edge; R8 read layout
      chk("R2 hold", core_hold_o, h);
      chk("R2 retry", cfg_retry_o, r);
      chk("R2 stest", self_test_o, t);
      chk("R8 rdata", reg_rdata_o, {t, r, h});
      chk("R4 oe0", pin_oe_o, 0);
      pin_i = ~pin_i;
      for (int k = 1; k < 4; k++) begin
        @(negedge clk_i);
        chk("R4 oe early", pin_oe_o, 0);
      end
      @(negedge clk_i);
      chk("R4 oe on", pin_oe_o, 1);
      chk("R3 strap held", reg_rdata_o, {t, r, h});
      // R9 address mux
      for (int a = 0; a < 6; a++) begin
        logic [22:0] av;
        av = 23'(32'h5A3C7 * (a + 1) + s * 977);
        addr_i = av;
        addr_hi_i = a[0];
        #1;
        chk("R9 mux", pin_o, a[0] ? 6'((av >> 17) & 23'h3f) : 6'((av >> 3) & 23'h3f));
      end
      // R7 zero write no effect
      wr(2'b00);
      chk("R7 zero write", reg_rdata_o, {t, r, h});
      // R6 clear hold only
      wr(2'b01);
      chk("R6 clr hold", reg_rdata_o, {t, r, 1'b0});
      // R6 clear retry only
      wr(2'b10);
      chk("R6 clr retry", reg_rdata_o, {t, 2'b00});
      // R7 stays cleared, self-test untouched
      wr(2'b11);
      repeat (3) @(negedge clk_i);
      chk("R7 stays clr", {core_hold_o, cfg_retry_o}, 0);
      chk("R7 stest kept", self_test_o, t);
      chk("R4 oe kept", pin_oe_o, 1);
    end
    // R5 reset partway through window, then re-arm
    @(negedge clk_i); rst_ni = 1'b0; pin_i = 6'b001000;
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b0; #1;
    chk("R5 oe cleared", pin_oe_o, 0);
    pin_i = 6'b000011;
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R5 resample", reg_rdata_o, 3'b110);
    repeat (3) begin
      @(negedge clk_i);
      chk("R5 oe early", pin_oe_o, 0);
    end
    @(negedge clk_i);
    chk("R5 oe on", pin_oe_o, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule